// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is a single SPI master that software drives through a small word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. There are three registers:

- **Control word (address 0):** holds the frame settings, the start bit and the busy flag.
- **Transmit word (address 1):** its upper bits hold the outgoing frame.
- **Receive word (address 2):** collects incoming bits from its low end.

A transfer drives a serial clock, a data-out line and one of four active-low chip selects, and it samples a data-in line. Frames are 4 to 32 bits long.

To run a transfer, software first writes the left-aligned payload into the transmit word. It then writes the control word with the length, clock-rate divisor, idle clock level, capture enable, chip-select index and the start bit. It polls the busy flag until the flag reads 0, and then reads the received bits from the low end of the receive word.

The serial clock half-period is 2·(N+1) system clocks, where N is the 6-bit rate field. The full serial clock period is therefore 4·(N+1) system clocks.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, all three registers read 0, the serial clock is 0, all four chip selects are 1, and the busy flag (control bit 31) is 0.
- R2: The control word keeps idle level in bit 1, capture enable in bit 3, rate in bits 9:4, length in bits 22:16 and chip-select index in bits 24:23. All other control bits read 0 (bit 0 and bit 31 as in R3). The transmit word at address 1 reads back as written. Address 3 reads 0.
- R3: A control write with bit 0 set, made while idle with a length from 4 to 32, sets the busy flag from the next cycle. In that cycle bit 0 reads 1, and it reads 0 from the cycle after.
- R4: A start request with a length outside 4..32 starts nothing. Busy stays 0 and every chip select stays 1, but the fields are still stored.
- R5: With H = 2·(N+1), the following timing holds:
  - The selected chip select falls one cycle after the start write.
  - The first clock edge comes H cycles after the chip select falls.
  - The 2·L edges are spaced H cycles apart.
  - The chip select rises H cycles after the last edge, together with busy clearing.
  - Busy reads 1 for (2·L+1)·H+1 consecutive cycles.
- R6: During a transfer, only the chip select whose number equals the index field is low. The others stay high.
- R7: The data-out line carries transmit-word bits 31 down to 32−L, most significant first. It changes on each leading edge and is stable at the trailing edge.
- R8: With capture enable set, the data-in line is sampled on each trailing edge. When the transfer completes, the receive word holds the L received bits in bits L−1:0, with the first bit received at bit L−1 and zeros above.
- R9: With capture enable clear, a transfer leaves the receive word unchanged.
- R10: The serial clock idles at the level of control bit 1 and returns to that level after the last edge. A leading edge is one that moves away from this level.
- R11: Writes to the control word or the transmit word made while busy reads 1 are ignored. Both read back unchanged afterwards, and the running frame keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | CS_NUM | Active-low chip selects |

## Verification
Read data is combinational. A register write therefore becomes visible at the falling clock edge right after the rising edge that captured it, and the busy flag can be checked at that same falling edge.

The serial side runs one cycle behind the start write. The chip select falls one cycle after the write, and each later event is a whole multiple of H cycles after that. The bench timestamps every chip-select and clock transition and compares the differences with the multiples of H that it computes, rather than sampling at fixed cycles.

The busy duration is counted by polling at every falling edge. The received word and the transmitted bits are compared only after busy has been seen to read 0.

// File: rtl/spih_pkg.sv
package spih_pkg;
   localparam int REG_W   = 32;
   localparam int F_START = 0;
   localparam int F_POL   = 1;
   localparam int F_RDEN  = 3;
   localparam int F_RATE  = 4;
   localparam int F_LEN   = 16;
   localparam int F_CS    = 23;
   localparam int F_BUSY  = 31;
   localparam int RATE_FW = 6;
   localparam int LEN_FW  = 7;
   localparam int CS_FW   = 2;
   localparam int A_CTL   = 0;
   localparam int A_TXD   = 1;
   localparam int A_RXD   = 2;

   typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_SHIFT, PH_TAIL} phase_t;

   typedef struct packed {
      logic [CS_FW-1:0]   cs;
      logic [LEN_FW-1:0]  len;
      logic [RATE_FW-1:0] rate;
      logic               rden;
      logic               pol;
   } cfg_t;
endpackage

// File: rtl/spih_clkgen.sv
module spih_clkgen
   import spih_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [RATE_FW-1:0] rate,
   output logic               tick
);
   localparam int CNT_W = RATE_FW + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // half period of 2*(rate+1) cycles ends at count 2*rate+1
   assign last = {rate, 1'b1};
   assign tick = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spih_regs.sv
module spih_regs
   import spih_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int MIN_LEN = 4,
   parameter int MAX_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              eng_active,
   input  logic [REG_W-1:0]  rx_word,
   output cfg_t              cfg,
   output logic [REG_W-1:0]  tx_word,
   output logic              start_req,
   output logic              busy_all,
   output logic [REG_W-1:0]  bus_rdata
);
   logic              sel_ctl, sel_txd, sel_rxd;
   logic              wr_ctl, wr_txd, len_ok;
   logic [LEN_FW-1:0] new_len;
   logic [REG_W-1:0]  ctl_view;

   assign sel_ctl  = (bus_addr == ADDR_W'(A_CTL));
   assign sel_txd  = (bus_addr == ADDR_W'(A_TXD));
   assign sel_rxd  = (bus_addr == ADDR_W'(A_RXD));
   assign busy_all = start_req | eng_active;
   assign wr_ctl   = bus_wr && sel_ctl && !busy_all;
   assign wr_txd   = bus_wr && sel_txd && !busy_all;
   assign new_len  = bus_wdata[F_LEN +: LEN_FW];
   assign len_ok   = (new_len >= LEN_FW'(MIN_LEN)) && (new_len <= LEN_FW'(MAX_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         tx_word   <= '0;
         start_req <= 1'b0;
      end else begin
         start_req <= wr_ctl && bus_wdata[F_START] && len_ok;
         if (wr_ctl) begin
            cfg.pol  <= bus_wdata[F_POL];
            cfg.rden <= bus_wdata[F_RDEN];
            cfg.rate <= bus_wdata[F_RATE +: RATE_FW];
            cfg.len  <= new_len;
            cfg.cs   <= bus_wdata[F_CS +: CS_FW];
         end
         if (wr_txd)
            tx_word <= bus_wdata;
      end
   end

   always_comb begin
      ctl_view                     = '0;
      ctl_view[F_START]            = start_req;
      ctl_view[F_POL]              = cfg.pol;
      ctl_view[F_RDEN]             = cfg.rden;
      ctl_view[F_RATE +: RATE_FW]  = cfg.rate;
      ctl_view[F_LEN +: LEN_FW]    = cfg.len;
      ctl_view[F_CS +: CS_FW]      = cfg.cs;
      ctl_view[F_BUSY]             = busy_all;
   end

   always_comb begin
      if (sel_ctl)
         bus_rdata = ctl_view;
      else if (sel_txd)
         bus_rdata = tx_word;
      else if (sel_rxd)
         bus_rdata = rx_word;
      else
         bus_rdata = '0;
   end
endmodule

// File: rtl/spih_engine.sv
module spih_engine
   import spih_pkg::*;
#(
   parameter int CS_NUM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              tick,
   input  logic              pol,
   input  logic              rden,
   input  logic [LEN_FW-1:0] len,
   input  logic [CS_FW-1:0]  cs_idx,
   input  logic [REG_W-1:0]  tx_word,
   input  logic              miso,
   output logic              active,
   output logic              sclk,
   output logic              mosi,
   output logic [CS_NUM-1:0] cs_n,
   output logic [REG_W-1:0]  rx_word
);
   phase_t           ph;
   logic [7:0]       edge_q;
   logic [7:0]       lim;
   logic [REG_W-1:0] sh_q, rx_q;
   logic             sclk_q, mosi_q;
   logic             launch, finish;

   assign lim     = {len, 1'b0} - 8'd1;
   assign launch  = (ph == PH_IDLE) && go;
   assign finish  = (ph == PH_TAIL) && tick;
   assign active  = (ph != PH_IDLE);
   assign sclk    = sclk_q;
   assign mosi    = mosi_q;
   assign rx_word = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         edge_q <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               sclk_q <= pol;
               if (go) begin
                  ph     <= PH_LEAD;
                  sh_q   <= tx_word;
                  edge_q <= '0;
                  if (rden)
                     rx_q <= '0;
               end
            end
            PH_LEAD: begin
               if (tick) begin
                  ph     <= PH_SHIFT;
                  sclk_q <= ~sclk_q;
                  mosi_q <= sh_q[REG_W-1];
                  sh_q   <= {sh_q[REG_W-2:0], 1'b1};
                  edge_q <= 8'd1;
               end
            end
            PH_SHIFT: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  if (edge_q[0]) begin
                     if (rden)
                        rx_q <= {rx_q[REG_W-2:0], miso};
                     if (edge_q == lim)
                        ph <= PH_TAIL;
                     else
                        edge_q <= edge_q + 8'd1;
                  end else begin
                     mosi_q <= sh_q[REG_W-1];
                     sh_q   <= {sh_q[REG_W-2:0], 1'b1};
                     edge_q <= edge_q + 8'd1;
                  end
               end
            end
            PH_TAIL: begin
               if (tick)
                  ph <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
      logic cs_bit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cs_bit <= 1'b1;
         else if (launch)
            cs_bit <= (cs_idx != CS_FW'(i));
         else if (finish)
            cs_bit <= 1'b1;
      end
      assign cs_n[i] = cs_bit;
   end
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
   import spih_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int CS_NUM  = 4,
   parameter int MIN_LEN = 4,
   parameter int MAX_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [CS_NUM-1:0] spi_cs_n
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover three registers");
   end
   if (CS_NUM < 1 || CS_NUM > (1 << CS_FW)) begin : g_bad_cs
      $error("CS_NUM must be 1 to 4");
   end
   if (MIN_LEN < 1 || MAX_LEN > REG_W || MIN_LEN > MAX_LEN) begin : g_bad_len
      $error("frame length limits out of range");
   end

   cfg_t             cfg_q;
   logic [REG_W-1:0] tx_word, rx_word;
   logic             start_req, busy_all, eng_active, tick;

   spih_regs #(
      .ADDR_W (ADDR_W),
      .MIN_LEN(MIN_LEN),
      .MAX_LEN(MAX_LEN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .eng_active(eng_active),
      .rx_word   (rx_word),
      .cfg       (cfg_q),
      .tx_word   (tx_word),
      .start_req (start_req),
      .busy_all  (busy_all),
      .bus_rdata (bus_rdata)
   );

   spih_clkgen u_clkgen (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (eng_active),
      .rate (cfg_q.rate),
      .tick (tick)
   );

   spih_engine #(
      .CS_NUM(CS_NUM)
   ) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (start_req),
      .tick   (tick),
      .pol    (cfg_q.pol),
      .rden   (cfg_q.rden),
      .len    (cfg_q.len),
      .cs_idx (cfg_q.cs),
      .tx_word(tx_word),
      .miso   (spi_miso),
      .active (eng_active),
      .sclk   (spi_sclk),
      .mosi   (spi_mosi),
      .cs_n   (spi_cs_n),
      .rx_word(rx_word)
   );
endmodule

// File: rtl/spih_checker.sv
module spih_checker
   import spih_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int CS_NUM  = 4,
   parameter int MIN_LEN = 4,
   parameter int MAX_LEN = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic [CS_NUM-1:0] cs_n,
   input logic              sclk,
   input cfg_t              cfg,
   input logic [31:0]       tx_word
);
   logic ctl_wr, txd_wr, good_len;

   assign ctl_wr   = bus_wr && (bus_addr == ADDR_W'(A_CTL));
   assign txd_wr   = bus_wr && (bus_addr == ADDR_W'(A_TXD));
   assign good_len = (bus_wdata[F_LEN +: LEN_FW] >= LEN_FW'(MIN_LEN)) &&
                     (bus_wdata[F_LEN +: LEN_FW] <= LEN_FW'(MAX_LEN));

   assert_one_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

   assert_cs_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n != '1) |-> busy);

   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[F_START] && good_len && !busy) |=> busy);

   assert_bad_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !good_len && !busy) |=> !busy);

   assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_wr && busy) |=> $stable(tx_word));

   assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && busy) |=> $stable(cfg));

   assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (sclk == cfg.pol));
endmodule

bind spi_host_ctl spih_checker #(
   .ADDR_W (ADDR_W),
   .CS_NUM (CS_NUM),
   .MIN_LEN(MIN_LEN),
   .MAX_LEN(MAX_LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .busy     (busy_all),
   .cs_n     (spi_cs_n),
   .sclk     (spi_sclk),
   .cfg      (cfg_q),
   .tx_word  (tx_word)
);

// File: tb/spi_host_ctl_test.sv
module spi_host_ctl_test;
   localparam logic [1:0] CTL = 2'd0, TXD = 2'd1, RXD = 2'd2;

   logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire         sclk, mosi;
   logic        miso = 1'b0;
   wire  [3:0]  cs_n;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spi_host_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
      .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
   );

   // serial peer model and event timestamps
   logic        tb_pol = 1'b0;
   bit          mon_on = 0;
   logic [31:0] slv_word = '0, got = '0;
   int          nlead = 0, ntrail = 0, seen_cs = -1, multi = 0;
   time         t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;

   always @(sclk) begin
      if (mon_on && cs_n != 4'hF) begin
         if (sclk !== tb_pol) begin
            if (nlead == 0) t_first = $time;
            miso = slv_word[31];
            slv_word = slv_word << 1;
            nlead++;
         end else begin
            got = {got[30:0], mosi};
            ntrail++;
            t_last = $time;
         end
      end
   end

   always @(cs_n) begin
      if (mon_on) begin
         if (cs_n != 4'hF) begin
            t_fall = $time;
            if ($countones(~cs_n) != 1) multi++;
            for (int i = 0; i < 4; i++) if (!cs_n[i]) seen_cs = i;
         end else begin
            t_rise = $time;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] mk_ctl(input bit st, input bit p, input bit rd,
                                          input int rate, input int len, input int cs);
      return 32'(st) | (32'(p) << 1) | (32'(rd) << 3) | ((32'(rate) & 32'h3F) << 4) |
             ((32'(len) & 32'h7F) << 16) | ((32'(cs) & 32'h3) << 23);
   endfunction

   task automatic xfer(input int len, input int rate, input bit pol, input int csi,
                       input bit rden, input logic [31:0] pay, input logic [31:0] slv,
                       input bit poke);
      logic [63:0] mask;
      logic [31:0] txw, rbefore, r, ctl;
      int h, cnt;
      mask = (64'd1 << len) - 64'd1;
      h    = 2 * (rate + 1);
      txw  = 32'((((64'(pay) & mask) << (32 - len)) | ((64'd1 << (32 - len)) - 64'd1)));
      ctl  = mk_ctl(0, pol, rden, rate, len, csi);
      bus_write(CTL, ctl);
      @(negedge clk);
      chk("R10", "idle clock level before start", 64'(sclk), 64'(pol));
      bus_write(TXD, txw);
      bus_read(RXD, rbefore);
      slv_word = 32'((64'(slv) & mask) << (32 - len));
      tb_pol = pol; got = '0; nlead = 0; ntrail = 0; seen_cs = -1; multi = 0;
      mon_on = 1;
      bus_write(CTL, ctl | 32'h1);
      bus_read(CTL, r);
      chk("R3", "busy right after start", 64'(r[31]), 64'd1);
      chk("R3", "start bit first cycle", 64'(r[0]), 64'd1);
      cnt = 0;
      while (r[31] && cnt < 100000) begin
         cnt++;
         @(negedge clk);
         if (poke && cnt == 4) begin
            bus_wr = 1'b1; bus_addr = TXD; bus_wdata = ~txw;
         end else if (poke && cnt == 5) begin
            bus_addr = CTL; bus_wdata = mk_ctl(1, !pol, !rden, rate ^ 1, 5, csi ^ 1);
         end else begin
            bus_wr = 1'b0;
            bus_read(CTL, r);
            if (cnt == 1) chk("R3", "start bit self-clears", 64'(r[0]), 64'd0);
         end
      end
      mon_on = 0;
      chk("R5", "busy cycles", 64'(cnt), 64'((2 * len + 1) * h + 1));
      chk("R5", "select to first edge", 64'(t_first - t_fall), 64'(h * 20));
      chk("R5", "last edge to release", 64'(t_rise - t_last), 64'(h * 20));
      chk("R5", "edge span", 64'(t_last - t_first), 64'((2 * len - 1) * h * 20));
      chk("R5", "leading edge count", 64'(nlead), 64'(len));
      chk("R5", "trailing edge count", 64'(ntrail), 64'(len));
      chk("R6", "selected line", 64'(seen_cs), 64'(csi));
      chk("R6", "single select", 64'(multi), 64'd0);
      chk("R7", "serial out bits", 64'(got) & mask, 64'(pay) & mask);
      bus_read(RXD, r);
      if (rden) chk("R8", "received word", 64'(r), 64'(slv) & mask);
      else      chk("R9", "receive word kept", 64'(r), 64'(rbefore));
      chk("R10", "clock back at idle", 64'(sclk), 64'(pol));
      if (poke) begin
         bus_read(TXD, r);
         chk("R11", "transmit word kept", 64'(r), 64'(txw));
         bus_read(CTL, r);
         chk("R11", "control word kept", 64'(r), 64'(ctl));
      end
   endtask

   initial begin
      #(64'd200000 * 20);
      n_chk++; n_err++;
      $display("FAIL R5 watchdog expired: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      int bad_len [4] = '{0, 3, 33, 127};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      bus_read(CTL, r); chk("R1", "control after reset", 64'(r), 64'd0);
      bus_read(TXD, r); chk("R1", "transmit after reset", 64'(r), 64'd0);
      bus_read(RXD, r); chk("R1", "receive after reset", 64'(r), 64'd0);
      chk("R1", "clock after reset", 64'(sclk), 64'd0);
      chk("R1", "selects after reset", 64'(cs_n), 64'hF);

      // R2 layout and readback
      bus_write(CTL, 32'hFFFF_FFFE);
      bus_read(CTL, r); chk("R2", "control field mask", 64'(r), 64'h01FF_03FA);
      bus_write(TXD, 32'hA5C3_1E78);
      bus_read(TXD, r); chk("R2", "transmit readback", 64'(r), 64'hA5C3_1E78);
      bus_read(2'd3, r); chk("R2", "unused address", 64'(r), 64'd0);

      // R4 illegal lengths
      for (int k = 0; k < 4; k++) begin
         bus_write(CTL, mk_ctl(1, 0, 1, 2, bad_len[k], 1));
         bus_read(CTL, r);
         chk("R4", "no busy for bad length", 64'(r[31]), 64'd0);
         chk("R4", "length still stored", 64'(r[22:16]), 64'(bad_len[k]));
         @(negedge clk); @(negedge clk);
         chk("R4", "selects stay high", 64'(cs_n), 64'hF);
      end

      // length sweep across the whole legal range
      for (int len = 4; len <= 32; len++) begin
         xfer(len, len % 3, len[0], len % 4, 1'b1,
              32'(len) * 32'h9E37_79B1 ^ 32'h5A5A_5A5A,
              32'(len) * 32'h7F4A_7C15 + 32'd3, 1'b0);
      end

      // divisor sweep
      xfer(8, 5, 1'b0, 2, 1'b1, 32'hC6, 32'h39, 1'b0);
      xfer(8, 17, 1'b1, 3, 1'b1, 32'h81, 32'hFE, 1'b0);
      xfer(8, 63, 1'b0, 0, 1'b1, 32'h5A, 32'hA5, 1'b0);

      // capture disabled
      xfer(12, 1, 1'b1, 1, 1'b0, 32'hABC, 32'h123, 1'b0);

      // writes during busy
      xfer(8, 3, 1'b1, 2, 1'b1, 32'h96, 32'h6B, 1'b1);

      finish_run();
   end
endmodule